// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Timed Pulse Outputs

This block is an eight-pin general-purpose I/O port run by a byte-wide index/data register interface. Each pin has an output-enable bit, a drive-type bit (push-pull or open-drain) and a value bit. Pins 4, 5 and 6 can also be placed in pulse mode. In that mode a write of 1 to the value bit sends one active-low pulse, whose length in clock cycles comes from a port-wide width register, and the value bit clears itself when the pulse ends. The other pins always work in level mode, where the value bit sets the pin level.

The pads appear as three separate vectors: output level, output enable and input. Pad inputs pass through a two-flop synchroniser into a read-only status byte, with bit n holding pin n. That byte can be read at two indices. Reads are combinational on the addressed index. A write takes effect at the clock edge where `reg_wr` is high.

Top module: `gpio_pulse_port`

## Requirements
- R1: After reset the value register reads 0x0F, the output-enable register reads 0x00, the drive register reads 0xFF, the mode register reads 0x00, the width register reads 10, and no pad is driven. Register indices: output-enable 0xF0, value 0xF1, status 0xF2, drive 0xF3, mode 0xF4, width 0xF5, status alias 0x06.
- R2: A pin in level mode with its output-enable bit set and its drive bit set drives its value bit onto `pad_out`, with `pad_oe` high, from the edge of the write onward.
- R3: When a driven pin's drive bit is 0, a level of 1 leaves `pad_oe` low (open-drain). A level of 0 is still driven low.
- R4: A pin whose output-enable bit is 0 never has `pad_oe` high, whatever its mode, value or drive bits.
- R5: Only mode bits 4, 5 and 6 can be written. The other mode bits always read 0, so writing 0xFF to the mode register reads back 0x70.
- R6: In pulse mode, writing 1 to the value bit drives the pin low for exactly W cycles, starting at the write edge, where W is the width register. After that the pin returns to its idle high level, which follows the rule of R3.
- R7: In pulse mode the value bit reads 1 while the pulse runs and reads 0 from the edge where the pulse ends.
- R8: In pulse mode, a write of 1 to a pin whose pulse is running, including in the pulse's last cycle, is ignored and does not lengthen or restart the pulse. A write of 0 in pulse mode is ignored.
- R9: A width register value of 0 gives a one-cycle pulse.
- R10: A change on `pad_in` appears in the status byte after the second rising edge, and not after the first.
- R11: The status byte reads the same at index 0xF2 and at index 0x06. Unmapped indices read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad drive enables |

## Verification
Two things can fall in the same cycle: a pulse ending and a host write to the value register. The bench starts a four-cycle pulse on pin 4 and times a write of 0x11 so that it lands on the pulse's final edge. The write must set level pin 0 and must not restart pin 4. The check passes when the value register reads 0x01 and pin 4 stays idle high afterwards. A second collision writes into the middle of a running pulse, and the bench counts the remaining low cycles to confirm the pulse length did not change.

// File: rtl/gpio_pkg.sv
// Package: register indices and sizes shared by the GPIO port and its bench.
// Assumes an 8-bit index/data register interface.
package gpio_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] IDX_OE         = 8'hF0;
    localparam logic [ADDR_W-1:0] IDX_VAL        = 8'hF1;
    localparam logic [ADDR_W-1:0] IDX_STATUS     = 8'hF2;
    localparam logic [ADDR_W-1:0] IDX_DRV        = 8'hF3;
    localparam logic [ADDR_W-1:0] IDX_MODE       = 8'hF4;
    localparam logic [ADDR_W-1:0] IDX_WIDTH      = 8'hF5;
    localparam logic [ADDR_W-1:0] IDX_STATUS_ALT = 8'h06;
endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop synchroniser for a vector of pad inputs.
// Assumes each bit is handled on its own; no bus coherency is implied.
module gpio_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two registers in series; both clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

    // R10: the output is the first stage delayed by one cycle
    a_r10_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        stage2 == $past(stage1));
endmodule

// File: rtl/gpio_pulse_timer.sv
// Module: one-shot pulse timer for a single pin.
// Assumes start is ignored while busy; a width of 0 is treated as 1.
module gpio_pulse_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] width,
    output logic          busy,
    output logic          done
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;

    // Width 0 gets the minimum one-cycle length.
    always_comb load_val = (width == '0) ? CW'(1) : width;

    // Load on an idle start, count down while busy, stop at the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= load_val;
            end
        end else if (cnt == CW'(1)) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            cnt <= cnt - CW'(1);
        end
    end

    assign done = busy && (cnt == CW'(1));

    // R8: a start during a running pulse does not reload the counter
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && cnt != CW'(1)) |=> (busy && cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/gpio_pulse_port.sv
// Module: eight-pin GPIO port with level/pulse outputs, open-drain option,
// output enables and a synchronised status byte.
// Assumes the host writes through the index/data port; reads are combinational.
module gpio_pulse_port
    import gpio_pkg::*;
#(
    parameter int unsigned      NPINS      = 8,
    parameter logic [NPINS-1:0] PULSE_MASK = 8'b0111_0000,
    parameter logic [NPINS-1:0] VAL_RST    = 8'b0000_1111,
    parameter logic [NPINS-1:0] DRV_RST    = 8'hFF,
    parameter int unsigned      PW_W       = 8,
    parameter int unsigned      PW_RST     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    localparam logic [PW_W-1:0] WIDTH_RST = PW_W'(PW_RST);

    logic [NPINS-1:0] oe_r, drv_r, mode_r, val_r, val_nxt;
    logic [PW_W-1:0]  width_r;
    logic [NPINS-1:0] busy, done, lvl, status;
    logic             wr_val;

    assign wr_val = reg_wr && (reg_addr == IDX_VAL);

    // Configuration registers; mode bits exist only on pulse-capable pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_r    <= '0;
            drv_r   <= DRV_RST;
            mode_r  <= '0;
            width_r <= WIDTH_RST;
        end else if (reg_wr) begin
            case (reg_addr)
                IDX_OE:    oe_r    <= reg_wdata[NPINS-1:0];
                IDX_DRV:   drv_r   <= reg_wdata[NPINS-1:0];
                IDX_MODE:  mode_r  <= reg_wdata[NPINS-1:0] & PULSE_MASK;
                IDX_WIDTH: width_r <= reg_wdata[PW_W-1:0];
                default:   ;
            endcase
        end
    end

    // Value register takes the per-pin next state built below.
    always_ff @(posedge clk) begin
        if (!rst_n) val_r <= VAL_RST;
        else        val_r <= val_nxt;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        if (PULSE_MASK[i]) begin : g_pulse
            logic start_i;
            assign start_i = wr_val && mode_r[i] && reg_wdata[i];

            gpio_pulse_timer #(.CW(PW_W)) u_timer (
                .clk   (clk),
                .rst_n (rst_n),
                .start (start_i),
                .width (width_r),
                .busy  (busy[i]),
                .done  (done[i])
            );

            // End of pulse clears; pulse-mode writes only set an idle bit.
            assign val_nxt[i] = done[i]                  ? 1'b0 :
                                !wr_val                  ? val_r[i] :
                                !mode_r[i]               ? reg_wdata[i] :
                                (start_i && !busy[i])    ? 1'b1 : val_r[i];
            // Active-low pulse, idle high in pulse mode.
            assign lvl[i] = mode_r[i] ? ~busy[i] : val_r[i];

            // R7: the value bit is clear once the pulse has ended
            a_r7_clear_on_end: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(busy[i]) |-> !val_r[i]);
            // R6: a running pulse drives the enabled pin low
            a_r6_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
                (busy[i] && mode_r[i] && oe_r[i]) |-> (pad_oe[i] && !pad_out[i]));
        end else begin : g_level
            assign busy[i]    = 1'b0;
            assign done[i]    = 1'b0;
            assign val_nxt[i] = wr_val ? reg_wdata[i] : val_r[i];
            assign lvl[i]     = val_r[i];
        end
    end

    // Pad drive: disabled pins float; open-drain floats a high level.
    always_comb begin
        pad_out = lvl;
        pad_oe  = oe_r & (~lvl | drv_r);
    end

    gpio_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (status)
    );

    // Read multiplexer; status is reachable at two indices.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_OE:                     reg_rdata = DATA_W'(oe_r);
            IDX_VAL:                    reg_rdata = DATA_W'(val_r);
            IDX_DRV:                    reg_rdata = DATA_W'(drv_r);
            IDX_MODE:                   reg_rdata = DATA_W'(mode_r);
            IDX_WIDTH:                  reg_rdata = DATA_W'(width_r);
            IDX_STATUS, IDX_STATUS_ALT: reg_rdata = DATA_W'(status);
            default:                    reg_rdata = '0;
        endcase
    end

    // R4: a pin with its enable clear is never driven
    a_r4_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~oe_r) == '0);
endmodule

// File: tb/gpio_pulse_port_bench.sv
module gpio_pulse_port_bench;
    import gpio_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_pulse_port u_gpio_pulse_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    // Counts consecutive negedges (from the current one) with pin p driven low.
    task automatic count_low(input int p, output int n);
        n = 0;
        while (pad_oe[p] && !pad_out[p] && n < 300) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(IDX_VAL, d);   check("R1 val", d, 8'h0F);
        rd(IDX_OE, d);    check("R1 oe", d, 8'h00);
        rd(IDX_DRV, d);   check("R1 drv", d, 8'hFF);
        rd(IDX_MODE, d);  check("R1 mode", d, 8'h00);
        rd(IDX_WIDTH, d); check("R1 width", d, 8'd10);
        check("R1 pad_oe", pad_oe, 8'h00);
    endtask

    task automatic t_level;
        wr(IDX_OE, 8'h0F);
        wr(IDX_VAL, 8'h05);
        check("R2 pad_out", pad_out & 8'h0F, 8'h05);
        check("R2 pad_oe", pad_oe & 8'h0F, 8'h0F);
        wr(IDX_VAL, 8'h0A);
        check("R2 pad_out", pad_out & 8'h0F, 8'h0A);
    endtask

    task automatic t_open_drain;
        wr(IDX_DRV, 8'hF0);
        check("R3 high floats, low driven", pad_oe & 8'h0F, 8'h05);
        wr(IDX_DRV, 8'hFF);
    endtask

    task automatic t_disabled;
        wr(IDX_OE, 8'h00);
        wr(IDX_VAL, 8'h00);
        check("R4 no drive", pad_oe, 8'h00);
        wr(IDX_MODE, 8'h10);
        wr(IDX_VAL, 8'h10);
        check("R4 no drive in pulse", pad_oe, 8'h00);
        repeat (12) @(negedge clk);
    endtask

    task automatic t_mode_mask;
        logic [7:0] d;
        wr(IDX_MODE, 8'hFF);
        rd(IDX_MODE, d);
        check("R5 mode mask", d, 8'h70);
        wr(IDX_MODE, 8'h10);
    endtask

    task automatic t_pulse;
        logic [7:0] d; int n;
        wr(IDX_OE, 8'h10);
        wr(IDX_WIDTH, 8'd10);
        check("R6 idle high", {pad_oe[4], pad_out[4]}, 2'b11);
        wr(IDX_VAL, 8'h10);
        rd(IDX_VAL, d);
        check("R7 busy reads 1", d[4], 1'b1);
        count_low(4, n);
        check("R6 width 10", n, 10);
        rd(IDX_VAL, d);
        check("R7 cleared", d[4], 1'b0);
        check("R6 back to idle", {pad_oe[4], pad_out[4]}, 2'b11);
        wr(IDX_DRV, 8'h00);
        check("R6 idle open-drain", pad_oe[4], 1'b0);
        wr(IDX_DRV, 8'hFF);
    endtask

    task automatic t_ignore;
        int n; logic [7:0] d;
        wr(IDX_WIDTH, 8'd5);
        wr(IDX_VAL, 8'h10);      // pulse starts, 1 low sample consumed here
        wr(IDX_VAL, 8'h10);      // lands on second cycle of pulse
        count_low(4, n);
        check("R8 no extension", n, 3);
        wr(IDX_VAL, 8'h00);
        check("R8 write 0 ignored pin idle", {pad_oe[4], pad_out[4]}, 2'b11);
        rd(IDX_VAL, d);
        check("R8 write 0 no pulse", d[4], 1'b0);
    endtask

    task automatic t_width0;
        int n;
        wr(IDX_WIDTH, 8'd0);
        wr(IDX_VAL, 8'h10);
        count_low(4, n);
        check("R9 width 0 one cycle", n, 1);
    endtask

    task automatic t_collide;
        logic [7:0] d;
        wr(IDX_OE, 8'h11);
        wr(IDX_WIDTH, 8'd4);
        wr(IDX_VAL, 8'h10);
        @(negedge clk); @(negedge clk);
        wr(IDX_VAL, 8'h11);      // on the pulse's final edge
        rd(IDX_VAL, d);
        check("R8 collide value", d, 8'h01);
        check("R8 collide no restart", {pad_oe[4], pad_out[4]}, 2'b11);
        @(negedge clk);
        check("R8 collide still idle", {pad_oe[4], pad_out[4]}, 2'b11);
        check("R2 collide level pin", pad_out[0], 1'b1);
    endtask

    task automatic t_status;
        logic [7:0] d;
        @(negedge clk); pad_in = 8'hA5;
        @(negedge clk);
        rd(IDX_STATUS, d); check("R10 not after one edge", d, 8'h00);
        @(negedge clk);
        rd(IDX_STATUS, d); check("R10 after two edges", d, 8'hA5);
        rd(IDX_STATUS_ALT, d); check("R11 alias", d, 8'hA5);
        rd(8'h33, d); check("R11 unmapped", d, 8'h00);
    endtask

    initial begin
        #400000;
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_level;
        t_open_drain;
        t_disabled;
        t_mode_mask;
        t_pulse;
        t_ignore;
        t_width0;
        t_collide;
        t_status;
        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule